// File: doc/BRIEF.md
# Four-Channel Pulse Counter Bank with Accumulators

The block counts rising edges on four asynchronous pulse inputs. Each input is synchronized, edge-detected and counted by a narrow per-channel counter. A periodic interval tick drains every counter into a wider per-channel accumulator and restarts the counter. A separate snapshot strobe starts a processing pass. It moves each accumulator total into a holding register and clears the accumulator. The held totals then pass through an optional gain-and-offset stage that gives one signed result per channel.

Inputs 0 and 2 can each be put into a chained mode. In that mode the two narrow counters of a pair form one counter of twice the width, which allows higher pulse rates between ticks. The partner input (1 or 3) is then ignored. The tick generator and any register access sit outside this block. Gains, offsets and pair selection come in as plain ports.

Top module: `pulse_bank`

## Requirements
- R1: After reset, every hold_o lane, every result_o lane, cnt_ovf_o, acc_ovf_o and result_valid_o read zero.
- R2: Each pulse input passes a two-flop synchronizer. A rising edge is counted at the third rising clock edge after the input goes high. A level held high counts exactly once.
- R3: On tick_i, each channel's counter value is added into that channel's accumulator and the counter restarts. An edge that is counted in the same cycle as the tick goes into the next interval and is never lost.
- R4: In split mode, an 8-bit counter holds at 255. An edge that arrives while it is at 255 is dropped and sets cnt_ovf_o[ch]. Exactly 255 edges in one interval do not set the flag.
- R5: An accumulator whose sum would exceed 65535 holds at 65535 and sets the sticky flag acc_ovf_o[ch].
- R6: When pair_en_i[p] is 1, the counters of channels 2p and 2p+1 form one 16-bit counter on input 2p. That counter holds at 65535 and sets cnt_ovf_o[2p] when it drops an edge. Input 2p+1 is then ignored and adds nothing to its accumulator.
- R7: On snap_i, hold_o lane ch takes the accumulator total and the accumulator is cleared. Both of the channel's flags clear, unless a flag-setting event happens in the same cycle.
- R8: When snap_i and tick_i coincide, hold_o takes the total from before that tick. The counts drained by that tick start the next accumulation.
- R9: One cycle after hold_o updates, result_o lane ch equals gain*hold + offset, truncated to 32-bit two's complement. Gain and offset are signed 16-bit values and hold is unsigned. result_valid_o pulses high for that one cycle.
- R10: hold_o and result_o change only in response to a snapshot. They stay unchanged across ticks and input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 4 | Asynchronous pulse inputs, one per channel |
| tick_i | input | 1 | Interval tick: drain counters into accumulators |
| snap_i | input | 1 | Snapshot strobe: accumulators to hold, then clear |
| pair_en_i | input | 2 | Bit p chains channels 2p and 2p+1 on input 2p |
| gain_i | input | 64 | Signed 16-bit gain per channel, lane ch at [16ch+15:16ch] |
| offset_i | input | 64 | Signed 16-bit offset per channel, same lane layout |
| hold_o | output | 64 | Held 16-bit totals, lane ch at [16ch+15:16ch] |
| cnt_ovf_o | output | 4 | Sticky counter-dropped-edge flags |
| acc_ovf_o | output | 4 | Sticky accumulator saturation flags |
| result_o | output | 128 | Signed 32-bit scaled results, lane ch at [32ch+31:32ch] |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench targets the following corner cases:
- An edge that is counted in the same cycle as a tick. A design that clears the counter without keeping that edge would come up one count short.
- A snapshot that coincides with a tick. A wrong design would either lose the drained counts or fold them into the wrong pass.
- Exactly 255 edges against 256 edges in one interval. This exposes a flag that is set at the limit rather than on a drop, or a counter that wraps to zero.
- A long run in chained mode that drives the accumulator past 65535. A design without saturation would report a small wrapped total and no flag.
- Traffic on the idle partner input in chained mode. A design that still counts it would show a nonzero total on the partner channel.

// File: rtl/pulse_bank_pkg.sv
package pulse_bank_pkg;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_CHAIN = 1'b1} pair_mode_e;
endpackage

// File: rtl/pb_edge_sync.sv
module pb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], in_i};
  end

  // last stage holds the previous synchronized level
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pb_pair_counter.sv
module pb_pair_counter
  import pulse_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  pair_mode_e           mode_i,
  input  logic                 tick_i,
  input  logic                 rise_a_i,
  input  logic                 rise_b_i,
  output logic [2*CNT_W-1:0]   cnt_a_o,
  output logic [2*CNT_W-1:0]   cnt_b_o,
  output logic                 drop_a_o,
  output logic                 drop_b_o
);
  localparam int unsigned PW = 2 * CNT_W;

  logic [CNT_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic             chain;

  assign chain = (mode_i == MODE_CHAIN);

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    drop_a_o = 1'b0;
    drop_b_o = 1'b0;
    if (chain) begin
      if (tick_i) begin
        {hi_d, lo_d} = PW'(rise_a_i);
      end else if (rise_a_i) begin
        if (&{hi_q, lo_q}) drop_a_o = 1'b1;
        else               {hi_d, lo_d} = {hi_q, lo_q} + PW'(1);
      end
    end else begin
      if (tick_i)        lo_d = CNT_W'(rise_a_i);
      else if (rise_a_i) begin
        if (&lo_q) drop_a_o = 1'b1;
        else       lo_d = lo_q + CNT_W'(1);
      end
      if (tick_i)        hi_d = CNT_W'(rise_b_i);
      else if (rise_b_i) begin
        if (&hi_q) drop_b_o = 1'b1;
        else       hi_d = hi_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_a_o = chain ? {hi_q, lo_q} : {{CNT_W{1'b0}}, lo_q};
  assign cnt_b_o = chain ? '0 : {{CNT_W{1'b0}}, hi_q};
endmodule

// File: rtl/pb_accum.sv
module pb_accum #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             snap_i,
  input  logic [IN_W-1:0]  add_i,
  input  logic             drop_i,
  output logic [ACC_W-1:0] hold_o,
  output logic             acc_ovf_o,
  output logic             cnt_ovf_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(add_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      hold_o    <= '0;
      acc_ovf_o <= 1'b0;
      cnt_ovf_o <= 1'b0;
    end else begin
      cnt_ovf_o <= (cnt_ovf_o & ~snap_i) | drop_i;
      if (snap_i) begin
        hold_o    <= acc_q;
        acc_q     <= tick_i ? ACC_W'(add_i) : '0;
        acc_ovf_o <= 1'b0;
      end else if (tick_i) begin
        acc_q     <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
        acc_ovf_o <= acc_ovf_o | sum[ACC_W];
      end
    end
  end
endmodule

// File: rtl/pb_scale.sv
module pb_scale #(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned RES_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  hold_i,
  input  logic [COEF_W-1:0] gain_i,
  input  logic [COEF_W-1:0] offset_i,
  output logic [RES_W-1:0]  result_o
);
  localparam int unsigned PW = COEF_W + ACC_W + 1;

  logic signed [PW-1:0] prod, total;

  assign prod  = $signed(gain_i) * $signed({1'b0, hold_i});
  assign total = prod + $signed({{(PW-COEF_W){offset_i[COEF_W-1]}}, offset_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_o <= '0;
    else if (en_i) result_o <= total[RES_W-1:0];
  end
endmodule

// File: rtl/pulse_bank.sv
module pulse_bank
  import pulse_bank_pkg::*;
#(
  parameter int unsigned N_PAIRS     = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned ACC_W       = 16,
  parameter int unsigned COEF_W      = 16,
  parameter int unsigned RES_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SCALE_EN    = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2*N_PAIRS-1:0]          pulse_i,
  input  logic                          tick_i,
  input  logic                          snap_i,
  input  logic [N_PAIRS-1:0]            pair_en_i,
  input  logic [2*N_PAIRS*COEF_W-1:0]   gain_i,
  input  logic [2*N_PAIRS*COEF_W-1:0]   offset_i,
  output logic [2*N_PAIRS*ACC_W-1:0]    hold_o,
  output logic [2*N_PAIRS-1:0]          cnt_ovf_o,
  output logic [2*N_PAIRS-1:0]          acc_ovf_o,
  output logic [2*N_PAIRS*RES_W-1:0]    result_o,
  output logic                          result_valid_o
);
  localparam int unsigned N_CH = 2 * N_PAIRS;
  localparam int unsigned PW   = 2 * CNT_W;

  logic [N_CH-1:0] rise, drop;
  logic [PW-1:0]   cnt [N_CH];
  logic            snap_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
    pb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (pulse_i[ch]),
      .rise_o (rise[ch])
    );
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pair_mode_e mode;
    assign mode = pair_en_i[p] ? MODE_CHAIN : MODE_SPLIT;
    pb_pair_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .tick_i   (tick_i),
      .rise_a_i (rise[2*p]),
      .rise_b_i (rise[2*p+1]),
      .cnt_a_o  (cnt[2*p]),
      .cnt_b_o  (cnt[2*p+1]),
      .drop_a_o (drop[2*p]),
      .drop_b_o (drop[2*p+1])
    );
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_acc
    pb_accum #(.IN_W(PW), .ACC_W(ACC_W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .snap_i    (snap_i),
      .add_i     (cnt[ch]),
      .drop_i    (drop[ch]),
      .hold_o    (hold_o[ch*ACC_W +: ACC_W]),
      .acc_ovf_o (acc_ovf_o[ch]),
      .cnt_ovf_o (cnt_ovf_o[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q         <= 1'b0;
      result_valid_o <= 1'b0;
    end else begin
      snap_q         <= snap_i;
      result_valid_o <= snap_q;
    end
  end

  if (SCALE_EN) begin : g_scale
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      pb_scale #(.ACC_W(ACC_W), .COEF_W(COEF_W), .RES_W(RES_W)) u_scale (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (snap_q),
        .hold_i   (hold_o[ch*ACC_W +: ACC_W]),
        .gain_i   (gain_i[ch*COEF_W +: COEF_W]),
        .offset_i (offset_i[ch*COEF_W +: COEF_W]),
        .result_o (result_o[ch*RES_W +: RES_W])
      );
    end
  end else begin : g_noscale
    assign result_o = '0;
  end
endmodule

// File: rtl/pulse_bank_chk.sv
module pulse_bank_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned ACC_W = 16,
  parameter int unsigned RES_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    snap_i,
  input logic [N_CH*ACC_W-1:0]   hold_o,
  input logic [N_CH-1:0]         cnt_ovf_o,
  input logic [N_CH-1:0]         acc_ovf_o,
  input logic [N_CH*RES_W-1:0]   result_o,
  input logic                    result_valid_o
);
  AST_VALID_AFTER_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> ##1 result_valid_o); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(hold_o)); // R10
  AST_RESULT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o)); // R10
  AST_ACC_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (acc_ovf_o == '0)); // R7
  AST_ACC_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ((acc_ovf_o & $past(acc_ovf_o)) == $past(acc_ovf_o))); // R5
  AST_CNT_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ((cnt_ovf_o & $past(cnt_ovf_o)) == $past(cnt_ovf_o))); // R4
endmodule

bind pulse_bank pulse_bank_chk #(.N_CH(2*N_PAIRS), .ACC_W(ACC_W), .RES_W(RES_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .snap_i         (snap_i),
  .hold_o         (hold_o),
  .cnt_ovf_o      (cnt_ovf_o),
  .acc_ovf_o      (acc_ovf_o),
  .result_o       (result_o),
  .result_valid_o (result_valid_o)
);

// File: tb/pulse_bank_test.sv
`timescale 1ns/1ps
module pulse_bank_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   pulse_i = '0;
  logic         tick_i = 1'b0, snap_i = 1'b0;
  logic [1:0]   pair_en_i = '0;
  logic [63:0]  gain_i = '0, offset_i = '0;
  logic [63:0]  hold_o;
  logic [3:0]   cnt_ovf_o, acc_ovf_o;
  logic [127:0] result_o;
  logic         result_valid_o;

  int checks = 0, errors = 0;
  int pend [4], acc [4], hold_m [4];
  bit covf [4], aovf [4];

  always #2.5 clk_i = ~clk_i;

  pulse_bank uut (.*);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit idle(int ch);
    return (ch % 2 == 1) && pair_en_i[ch/2];
  endfunction

  function automatic int lim(int ch);
    return ((ch % 2 == 0) && pair_en_i[ch/2]) ? 65535 : 255;
  endfunction

  task automatic model_edge(int ch);
    if (idle(ch)) return;
    if (pend[ch] == lim(ch)) covf[ch] = 1'b1;
    else pend[ch]++;
  endtask

  task automatic model_tick();
    for (int ch = 0; ch < 4; ch++) begin
      if (acc[ch] + pend[ch] > 65535) begin acc[ch] = 65535; aovf[ch] = 1'b1; end
      else acc[ch] += pend[ch];
      pend[ch] = 0;
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic burst(logic [3:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      for (int ch = 0; ch < 4; ch++) if (mask[ch]) model_edge(ch);
      pulse_i = mask;
      @(negedge clk_i);
      pulse_i = '0;
      @(negedge clk_i);
    end
    drain();
  endtask

  task automatic do_tick();
    model_tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic check_flags(string req);
    for (int ch = 0; ch < 4; ch++) begin
      check({req, " cnt_ovf"}, cnt_ovf_o[ch], covf[ch]);
      check({req, " acc_ovf"}, acc_ovf_o[ch], aovf[ch]);
    end
  endtask

  task automatic check_results();
    check("R9 valid", result_valid_o, 1);
    for (int ch = 0; ch < 4; ch++) begin
      longint r = longint'($signed(gain_i[ch*16 +: 16])) * hold_m[ch]
                + longint'($signed(offset_i[ch*16 +: 16]));
      check("R9 result", $signed(result_o[ch*32 +: 32]), longint'($signed(r[31:0])));
    end
    @(negedge clk_i);
    check("R9 valid one cycle", result_valid_o, 0);
  endtask

  // snap alone, or snap together with tick (R8)
  task automatic do_snap(bit with_tick);
    for (int ch = 0; ch < 4; ch++) begin
      hold_m[ch] = acc[ch];
      acc[ch] = with_tick ? pend[ch] : 0;
      if (with_tick) pend[ch] = 0;
      covf[ch] = 1'b0; aovf[ch] = 1'b0;
      gain_i[ch*16 +: 16]   = 16'($urandom);
      offset_i[ch*16 +: 16] = 16'($urandom);
    end
    snap_i = 1'b1; tick_i = with_tick;
    @(negedge clk_i);
    snap_i = 1'b0; tick_i = 1'b0;
    for (int ch = 0; ch < 4; ch++)
      check(with_tick ? "R8 hold" : "R7 hold", hold_o[ch*16 +: 16], hold_m[ch]);
    check_flags("R7 clear");
    @(negedge clk_i);
    check_results();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 195000) begin
        errors++; checks++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 195000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int ch = 0; ch < 4; ch++) begin
      pend[ch] = 0; acc[ch] = 0; hold_m[ch] = 0; covf[ch] = 0; aovf[ch] = 0;
    end
    repeat (3) @(negedge clk_i);
    check("R1 hold", hold_o, 0);
    check("R1 result", result_o == '0, 1);
    check("R1 flags", {cnt_ovf_o, acc_ovf_o}, 0);
    check("R1 valid", result_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3: distinct counts per channel over two intervals
    burst(4'b1111, 3); burst(4'b0101, 4); burst(4'b1000, 7);
    do_tick();
    check("R10 hold after tick", hold_o, 0);
    burst(4'b0011, 5);
    do_tick();
    check_flags("R3 flags");
    do_snap(1'b0);

    // R2: level held high counts once
    model_edge(1);
    pulse_i[1] = 1'b1;
    repeat (10) @(negedge clk_i);
    pulse_i[1] = 1'b0;
    drain();
    do_tick();
    do_snap(1'b0);

    // R3: edge counted in the same cycle as the tick
    burst(4'b0001, 4);
    pulse_i[0] = 1'b1;
    @(negedge clk_i);
    pulse_i[0] = 1'b0;
    @(negedge clk_i);
    model_tick();
    pend[0] = 1;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    drain();
    do_snap(1'b0);   // R3 expects 4 in this pass
    do_tick();
    do_snap(1'b0);   // R3 expects the carried edge

    // R4: exactly 255 on ch2, 256 on ch3
    burst(4'b1100, 255);
    burst(4'b1000, 1);
    check("R4 cnt_ovf ch2 clear", cnt_ovf_o[2], 0);
    check("R4 cnt_ovf ch3 set", cnt_ovf_o[3], 1);
    do_tick();
    check_flags("R4 flags");
    do_snap(1'b0);

    // R8: snapshot coinciding with tick
    burst(4'b0001, 6);
    do_tick();
    burst(4'b0011, 9);
    do_snap(1'b1);
    do_tick();
    do_snap(1'b0);

    // R6: chained pair 0, idle neighbour input toggled
    pair_en_i = 2'b01;
    @(negedge clk_i);
    burst(4'b0011, 300);
    check("R6 cnt_ovf ch0 clear", cnt_ovf_o[0], 0);
    do_tick();
    do_snap(1'b0);

    // random mix
    for (int it = 0; it < 20; it++) begin
      if (it % 5 == 0) begin
        pair_en_i = 2'($urandom);
        @(negedge clk_i);
      end
      for (int k = 0; k < 3; k++) begin
        burst(4'($urandom), int'($urandom_range(0, 12)));
        if ($urandom_range(0, 1) == 1) begin
          do_tick();
          for (int ch = 0; ch < 4; ch++)
            check("R10 hold stable", hold_o[ch*16 +: 16], hold_m[ch]);
        end
      end
      do_tick();
      check_flags("R6 random flags");
      do_snap(($urandom_range(0, 3) == 0));
      do_tick();
      do_snap(1'b0);
    end

    // R5: chained counter drives accumulator past 65535
    pair_en_i = 2'b01;
    @(negedge clk_i);
    burst(4'b0001, 32800);
    do_tick();
    check("R5 acc_ovf clear", acc_ovf_o[0], 0);
    burst(4'b0001, 32800);
    do_tick();
    check("R5 acc_ovf set", acc_ovf_o[0], 1);
    check_flags("R5 flags");
    do_snap(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule